// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact 32-bit processor core that retires one instruction per clock. Every cycle it presents the program counter on a word-wide instruction port, receives the 32-bit instruction word in the same cycle, and decodes it. It then reads up to two operands from a 32-entry register file, computes a result or an address, and at the next rising edge commits everything at once: the register write, the data memory write strobe and the new program counter.

Instructions use three fixed 32-bit layouts. The register-register layout carries a 6-bit major opcode of zero, three 5-bit register indices (source s, source t, destination d), a 5-bit shift distance and a 6-bit function selector. The immediate layout carries opcode, source s, target t and a 16-bit immediate. The jump layout carries opcode and a 26-bit word index. Both memories sit outside the block and read combinationally. A data write is taken by the memory at the clock edge that ends the cycle in which the write strobe is high. The core contains no pipeline, so there are no hazards and no stall logic.

Top module: `sc_core`

## Requirements
- R1: While reset is low, the instruction address is 0x00400000. After reset is released, each instruction that does not redirect control is followed by the instruction at address + 4.
- R2: Opcode 0 chooses by function field. 0x20 and 0x21 add, 0x22 and 0x23 subtract (s minus t), 0x24 AND, 0x25 OR, 0x26 XOR and 0x27 NOR. 0x2A sets 1 when s < t signed and 0x2B when s < t unsigned. The result goes to register d.
- R3: Function 0x00, 0x02 and 0x03 shift register t left, right-logical and right-arithmetic by the 5-bit shift field. Function 0x04, 0x06 and 0x07 do the same by bits [4:0] of register s. The result goes to register d.
- R4: Opcode 8 (add) and 0x0A (signed set-less-than) sign-extend the immediate. Opcode 0x0C (AND) and 0x0D (OR) zero-extend it. Opcode 0x0F places the immediate in bits [31:16] with zeros below. Each of these writes register t.
- R5: Opcode 35 loads the word at s + sign-extended immediate into register t. Opcode 43 writes register t to that address, with the write strobe high for exactly that cycle.
- R6: Opcode 4 branches when s equals t, and opcode 5 branches when they differ. The target is address + 4 + (sign-extended immediate × 4), so negative offsets go backwards.
- R7: Opcode 2 jumps to {bits [31:28] of address + 4, 26-bit index, 2'b00}. Opcode 3 does the same and also writes address + 4 into register 31.
- R8: Opcode 0 with function 0x08 jumps to the value held in register s and writes no register.
- R9: Register 0 always reads as zero, and writes addressed to it are dropped.
- R10: Any other opcode, and any other function value under opcode 0, writes no register and no memory, and falls through to address + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Address of the instruction being executed (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data (register t) |
| dmem_we | output | 1 | Store strobe, taken by the memory at the next rising edge |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, valid in the same cycle |

## Verification
A corrupted program counter shows on `imem_addr` in the cycle right after the faulty instruction, so every control-flow path is checked by where the program ends up and by which marker stores took place. A wrong register value is invisible until it is stored. For that reason, each computed result is written to its own data word in the very next instruction, and a fault then shows on `dmem_wdata` one cycle after the computing instruction. A stray write to a register or to memory under an unknown encoding shows either as a changed marker word or as an extra store strobe, and the number of strobes in each program is counted.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);
    localparam int SHW    = $clog2(XLEN);
    localparam int LINK_REG = NREGS - 1;

    // major opcodes
    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_JMP   = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    // function selectors under OP_REG
    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_SRLV = 6'h06;
    localparam logic [5:0] FN_SRAV = 6'h07;
    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] { DST_RT, DST_RD, DST_LINK } dst_sel_e;
    typedef enum logic [1:0] { OPB_REG, OPB_SIMM, OPB_ZIMM } opb_sel_e;
    typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_sel_e;

    typedef struct packed {
        logic     rf_we;
        dst_sel_e dst;
        opb_sel_e opb;
        alu_op_e  alu;
        wb_sel_e  wb;
        logic     mem_we;
        logic     br_eq;
        logic     br_ne;
        logic     jmp;
        logic     jreg;
        logic     sh_var;
        logic     illegal;
    } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e              op_i,
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    input  logic [$clog2(W)-1:0] sh_i,
    output logic [W-1:0]         y_o
);
    localparam int HALF = W / 2;

    always_comb begin
        y_o = '0;
        unique case (op_i)
            ALU_ADD:  y_o = a_i + b_i;
            ALU_SUB:  y_o = a_i - b_i;
            ALU_AND:  y_o = a_i & b_i;
            ALU_OR:   y_o = a_i | b_i;
            ALU_XOR:  y_o = a_i ^ b_i;
            ALU_NOR:  y_o = ~(a_i | b_i);
            ALU_SLT:  y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            ALU_SLTU: y_o = {{(W-1){1'b0}}, (a_i < b_i)};
            ALU_SLL:  y_o = b_i << sh_i;
            ALU_SRL:  y_o = b_i >> sh_i;
            ALU_SRA:  y_o = W'($signed(b_i) >>> sh_i);
            ALU_LUI:  y_o = {b_i[HALF-1:0], {HALF{1'b0}}};
            default:  y_o = a_i + b_i;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int NREG   = 32,
    parameter int W      = 32,
    parameter int NRD    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NRD-1:0][$clog2(NREG)-1:0] raddr_i,
    output logic [NRD-1:0][W-1:0]            rdata_o,
    input  logic                             we_i,
    input  logic [$clog2(NREG)-1:0]          waddr_i,
    input  logic [W-1:0]                     wdata_i
);
    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [0:NREG-1];

    // entry 0 is never written, so it keeps its reset value of zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we_i && (waddr_i != AW'(0))) begin
            regs[waddr_i] <= wdata_i;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata_o[p] = (raddr_i[p] == AW'(0)) ? '0 : regs[raddr_i[p]];
    end
endmodule

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] fn_i,
    output ctrl_t      ctrl_o
);
    always_comb begin
        ctrl_o     = '0;
        ctrl_o.dst = DST_RT;
        ctrl_o.opb = OPB_REG;
        ctrl_o.alu = ALU_ADD;
        ctrl_o.wb  = WB_ALU;
        unique case (op_i)
            OP_REG: begin
                ctrl_o.dst   = DST_RD;
                ctrl_o.rf_we = 1'b1;
                unique case (fn_i)
                    FN_ADD, FN_ADDU: ctrl_o.alu = ALU_ADD;
                    FN_SUB, FN_SUBU: ctrl_o.alu = ALU_SUB;
                    FN_AND:  ctrl_o.alu = ALU_AND;
                    FN_OR:   ctrl_o.alu = ALU_OR;
                    FN_XOR:  ctrl_o.alu = ALU_XOR;
                    FN_NOR:  ctrl_o.alu = ALU_NOR;
                    FN_SLT:  ctrl_o.alu = ALU_SLT;
                    FN_SLTU: ctrl_o.alu = ALU_SLTU;
                    FN_SLL:  ctrl_o.alu = ALU_SLL;
                    FN_SRL:  ctrl_o.alu = ALU_SRL;
                    FN_SRA:  ctrl_o.alu = ALU_SRA;
                    FN_SLLV: begin ctrl_o.alu = ALU_SLL; ctrl_o.sh_var = 1'b1; end
                    FN_SRLV: begin ctrl_o.alu = ALU_SRL; ctrl_o.sh_var = 1'b1; end
                    FN_SRAV: begin ctrl_o.alu = ALU_SRA; ctrl_o.sh_var = 1'b1; end
                    FN_JR: begin
                        ctrl_o.rf_we = 1'b0;
                        ctrl_o.jreg  = 1'b1;
                    end
                    default: begin
                        ctrl_o.rf_we   = 1'b0;
                        ctrl_o.illegal = 1'b1;
                    end
                endcase
            end
            OP_ADDI: begin ctrl_o.rf_we = 1'b1; ctrl_o.opb = OPB_SIMM; ctrl_o.alu = ALU_ADD; end
            OP_SLTI: begin ctrl_o.rf_we = 1'b1; ctrl_o.opb = OPB_SIMM; ctrl_o.alu = ALU_SLT; end
            OP_ANDI: begin ctrl_o.rf_we = 1'b1; ctrl_o.opb = OPB_ZIMM; ctrl_o.alu = ALU_AND; end
            OP_ORI:  begin ctrl_o.rf_we = 1'b1; ctrl_o.opb = OPB_ZIMM; ctrl_o.alu = ALU_OR;  end
            OP_LUI:  begin ctrl_o.rf_we = 1'b1; ctrl_o.opb = OPB_ZIMM; ctrl_o.alu = ALU_LUI; end
            OP_LOAD: begin
                ctrl_o.rf_we = 1'b1;
                ctrl_o.opb   = OPB_SIMM;
                ctrl_o.wb    = WB_MEM;
            end
            OP_STORE: begin
                ctrl_o.opb    = OPB_SIMM;
                ctrl_o.mem_we = 1'b1;
            end
            OP_BEQ: ctrl_o.br_eq = 1'b1;
            OP_BNE: ctrl_o.br_ne = 1'b1;
            OP_JMP: ctrl_o.jmp   = 1'b1;
            OP_JAL: begin
                ctrl_o.jmp   = 1'b1;
                ctrl_o.rf_we = 1'b1;
                ctrl_o.dst   = DST_LINK;
                ctrl_o.wb    = WB_LINK;
            end
            default: ctrl_o.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    localparam int IMM_W = 16;
    localparam int TGT_W = 26;

    logic [XLEN-1:0]   pc_q, pc_d, pc_plus4;
    logic [5:0]        op_f, fn_f;
    logic [RIDX_W-1:0] rs_f, rt_f, rd_f;
    logic [SHW-1:0]    sh_f;
    logic [IMM_W-1:0]  imm_f;
    logic [TGT_W-1:0]  tgt_f;

    ctrl_t ctrl;

    logic [1:0][RIDX_W-1:0] rf_raddr;
    logic [1:0][XLEN-1:0]   rf_rdata;
    logic [XLEN-1:0]        rs_val, rt_val;
    logic                   rf_we;
    logic [RIDX_W-1:0]      rf_waddr;
    logic [XLEN-1:0]        rf_wdata;

    logic [XLEN-1:0] simm, zimm, opb, alu_y, br_tgt, jmp_tgt;
    logic [SHW-1:0]  sh_amt;
    logic            src_eq, br_take;

    // instruction fields
    assign op_f  = imem_data[31:26];
    assign rs_f  = imem_data[25:21];
    assign rt_f  = imem_data[20:16];
    assign rd_f  = imem_data[15:11];
    assign sh_f  = imem_data[10:6];
    assign fn_f  = imem_data[5:0];
    assign imm_f = imem_data[15:0];
    assign tgt_f = imem_data[25:0];

    sc_decode u_dec (
        .op_i   (op_f),
        .fn_i   (fn_f),
        .ctrl_o (ctrl)
    );

    assign rf_raddr = {rt_f, rs_f};
    assign rs_val   = rf_rdata[0];
    assign rt_val   = rf_rdata[1];

    sc_regfile #(.NREG(NREGS), .W(XLEN), .NRD(2)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_i (rf_raddr),
        .rdata_o (rf_rdata),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata)
    );

    // operand B and shift distance
    assign simm = {{(XLEN-IMM_W){imm_f[IMM_W-1]}}, imm_f};
    assign zimm = {{(XLEN-IMM_W){1'b0}}, imm_f};

    always_comb begin
        unique case (ctrl.opb)
            OPB_SIMM: opb = simm;
            OPB_ZIMM: opb = zimm;
            default:  opb = rt_val;
        endcase
    end

    assign sh_amt = ctrl.sh_var ? rs_val[SHW-1:0] : sh_f;

    sc_alu #(.W(XLEN)) u_alu (
        .op_i (ctrl.alu),
        .a_i  (rs_val),
        .b_i  (opb),
        .sh_i (sh_amt),
        .y_o  (alu_y)
    );

    // write-back
    assign rf_we = ctrl.rf_we;

    always_comb begin
        unique case (ctrl.dst)
            DST_RD:   rf_waddr = rd_f;
            DST_LINK: rf_waddr = RIDX_W'(LINK_REG);
            default:  rf_waddr = rt_f;
        endcase
        unique case (ctrl.wb)
            WB_MEM:  rf_wdata = dmem_rdata;
            WB_LINK: rf_wdata = pc_plus4;
            default: rf_wdata = alu_y;
        endcase
    end

    // data memory port
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

    // next program counter
    assign pc_plus4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_plus4 + {simm[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[XLEN-1:TGT_W+2], tgt_f, 2'b00};
    assign src_eq   = (rs_val == rt_val);
    assign br_take  = (ctrl.br_eq & src_eq) | (ctrl.br_ne & ~src_eq);

    always_comb begin
        if (ctrl.jreg)     pc_d = rs_val;
        else if (ctrl.jmp) pc_d = jmp_tgt;
        else if (br_take)  pc_d = br_tgt;
        else               pc_d = pc_plus4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign imem_addr = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk #(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic [31:0] dmem_addr,
    input logic [31:0] dmem_wdata,
    input logic        dmem_we,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic [31:0] rf_wdata
);
    logic [5:0]  op, fn;
    logic [31:0] seimm, nxt, rel_tgt, abs_tgt;
    logic        is_seq;

    assign op      = imem_data[31:26];
    assign fn      = imem_data[5:0];
    assign seimm   = {{16{imem_data[15]}}, imem_data[15:0]};
    assign nxt     = imem_addr + 32'd4;
    assign rel_tgt = nxt + (seimm << 2);
    assign abs_tgt = {nxt[31:28], imem_data[25:0], 2'b00};
    assign is_seq  = (op == 6'h08) || (op == 6'h0D) || (op == 6'h23) || (op == 6'h2B);

    a_r1_reset_pc: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == RESET_PC));

    a_r1_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        is_seq |=> (imem_addr == $past(nxt)));

    a_r5_mem_address: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 6'h23) || (op == 6'h2B)) |-> (dmem_addr == rs_val + seimm));

    a_r5_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h2B) |-> (dmem_we && dmem_wdata == rt_val && !rf_we));

    a_r6_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (((op == 6'h04) && (rs_val == rt_val)) || ((op == 6'h05) && (rs_val != rt_val)))
        |=> (imem_addr == $past(rel_tgt)));

    a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 6'h02) || (op == 6'h03)) |=> (imem_addr == $past(abs_tgt)));

    a_r7_link_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h03) |-> (rf_we && rf_waddr == 5'd31 && rf_wdata == nxt));

    a_r8_register_jump: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 6'h00) && (fn == 6'h08)) |=> (imem_addr == $past(rs_val)));

    a_r9_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[25:21] == 5'd0) |-> (rs_val == 32'd0));

    a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h3F) |-> (!dmem_we && !rf_we));

    a_r10_unknown_next: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h3F) |=> (imem_addr == $past(nxt)));
endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
    localparam logic [31:0] BASE = 32'h0040_0000;
    localparam int NOPS = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [0:63];
    logic [31:0] dmem [0:255];
    logic [31:0] iidx;
    int          st_cnt;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    // memory models
    always_comb begin
        iidx = (imem_addr - BASE) >> 2;
        imem_data = (imem_addr >= BASE && iidx < 32'd64) ? imem[iidx[5:0]] : 32'h0;
    end
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) dmem[i] <= 32'hDEAD_BEEF;
            st_cnt <= 0;
        end else if (dmem_we) begin
            dmem[dmem_addr[9:2]] <= dmem_wdata;
            if (rst_n) st_cnt <= st_cnt + 1;
        end
    end

    // encoders
    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(int op, int idx);
        logic [31:0] t = BASE + 32'(4 * idx);
        return {6'(op), t[27:2]};
    endfunction

    function automatic logic [31:0] operand(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h1234_8765;
            6: return 32'hFFFF_8001;
            default: return 32'h0000_7FFF;
        endcase
    endfunction

    // k-th operation of the sweep: r3 <- f(r1 = a, r2 = b)
    function automatic logic [31:0] op_word(int k, logic [31:0] b);
        int s = int'(b[4:0]);
        case (k)
            0: return enc_r(1, 2, 3, 0, 'h20);
            1: return enc_r(1, 2, 3, 0, 'h21);
            2: return enc_r(1, 2, 3, 0, 'h22);
            3: return enc_r(1, 2, 3, 0, 'h23);
            4: return enc_r(1, 2, 3, 0, 'h24);
            5: return enc_r(1, 2, 3, 0, 'h25);
            6: return enc_r(1, 2, 3, 0, 'h26);
            7: return enc_r(1, 2, 3, 0, 'h27);
            8: return enc_r(1, 2, 3, 0, 'h2A);
            9: return enc_r(1, 2, 3, 0, 'h2B);
            10: return enc_r(0, 1, 3, s, 'h00);
            11: return enc_r(0, 1, 3, s, 'h02);
            12: return enc_r(0, 1, 3, s, 'h03);
            13: return enc_r(2, 1, 3, 0, 'h04);
            14: return enc_r(2, 1, 3, 0, 'h06);
            15: return enc_r(2, 1, 3, 0, 'h07);
            16: return enc_i('h08, 1, 3, b[15:0]);
            17: return enc_i('h0A, 1, 3, b[15:0]);
            18: return enc_i('h0C, 1, 3, b[15:0]);
            19: return enc_i('h0D, 1, 3, b[15:0]);
            default: return enc_i('h0F, 0, 3, b[15:0]);
        endcase
    endfunction

    function automatic logic [31:0] op_expect(int k, logic [31:0] a, logic [31:0] b);
        logic [31:0] si = {{16{b[15]}}, b[15:0]};
        logic [31:0] zi = {16'h0, b[15:0]};
        logic [4:0]  s  = b[4:0];
        case (k)
            0, 1: return a + b;
            2, 3: return a - b;
            4: return a & b;
            5: return a | b;
            6: return a ^ b;
            7: return ~(a | b);
            8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            9: return (a < b) ? 32'd1 : 32'd0;
            10, 13: return a << s;
            11, 14: return a >> s;
            12, 15: return 32'($signed(a) >>> s);
            16: return a + si;
            17: return ($signed(a) < $signed(si)) ? 32'd1 : 32'd0;
            18: return a & zi;
            19: return a | zi;
            default: return {b[15:0], 16'h0};
        endcase
    endfunction

    function automatic string op_tag(int k);
        if (k < 10) return "R2";
        if (k < 16) return "R3";
        return "R4";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_imem();
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    endtask

    // reset, clear data memory, release, optionally trace the first steps
    task automatic start_prog(bit trace);
        rst_n = 1'b0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R1 reset address", imem_addr, BASE);
        rst_n = 1'b1;
        if (trace) begin
            for (int k = 1; k <= 3; k++) begin
                @(negedge clk);
                chk("R1 sequential fetch", imem_addr, BASE + 32'(4 * k));
            end
        end
    endtask

    task automatic run_sweep(int ia, int ib, bit trace);
        logic [31:0] a = operand(ia);
        logic [31:0] b = operand(ib);
        clear_imem();
        imem[0] = enc_i('h0F, 0, 1, a[31:16]);
        imem[1] = enc_i('h0D, 1, 1, a[15:0]);
        imem[2] = enc_i('h0F, 0, 2, b[31:16]);
        imem[3] = enc_i('h0D, 2, 2, b[15:0]);
        for (int k = 0; k < NOPS; k++) begin
            imem[4 + 2 * k] = op_word(k, b);
            imem[5 + 2 * k] = enc_i('h2B, 0, 3, 16'(16 + 4 * k));
        end
        imem[4 + 2 * NOPS] = enc_i('h04, 0, 0, 16'hFFFF);
        start_prog(trace);
        repeat (55) @(negedge clk);
        for (int k = 0; k < NOPS; k++)
            chk($sformatf("%s op%0d a=%h b=%h", op_tag(k), k, a, b),
                dmem[4 + k], op_expect(k, a, b));
        chk("R5 store count in sweep", 32'(st_cnt), 32'(NOPS));
    endtask

    task automatic run_control();
        clear_imem();
        imem[0]  = enc_i('h08, 0, 1, 16'd5);
        imem[1]  = enc_i('h08, 0, 2, 16'd7);
        imem[2]  = enc_i('h04, 1, 2, 16'd1);
        imem[3]  = enc_i('h08, 0, 3, 16'd11);
        imem[4]  = enc_i('h05, 1, 2, 16'd1);
        imem[5]  = enc_i('h08, 0, 3, 16'd99);
        imem[6]  = enc_i('h04, 1, 1, 16'd1);
        imem[7]  = enc_i('h08, 0, 3, 16'd98);
        imem[8]  = enc_j('h03, 12);
        imem[9]  = enc_i('h2B, 0, 4, 16'd64);
        imem[10] = enc_j('h02, 16);
        imem[11] = enc_i('h08, 0, 3, 16'd97);
        imem[12] = enc_i('h08, 0, 4, 16'd42);
        imem[13] = enc_i('h2B, 0, 31, 16'd68);
        imem[14] = enc_r(31, 0, 0, 0, 'h08);
        imem[15] = enc_i('h08, 0, 3, 16'd96);
        imem[16] = enc_i('h2B, 0, 3, 16'd72);
        imem[17] = enc_i('h3F, 1, 3, 16'h1234);
        imem[18] = enc_r(1, 2, 3, 0, 'h01);
        imem[19] = enc_i('h08, 0, 0, 16'd123);
        imem[20] = enc_i('h2B, 0, 0, 16'd76);
        imem[21] = enc_i('h2B, 0, 3, 16'd80);
        imem[22] = enc_i('h08, 0, 7, 16'd100);
        imem[23] = enc_i('h2B, 7, 2, 16'hFFA4);
        imem[24] = enc_i('h23, 7, 8, 16'hFFA4);
        imem[25] = enc_i('h2B, 7, 8, 16'hFFF8);
        imem[26] = enc_j('h02, 28);
        imem[27] = enc_j('h02, 30);
        imem[28] = enc_i('h04, 0, 0, 16'hFFFE);
        imem[29] = enc_i('h08, 0, 6, 16'd2);
        imem[30] = enc_i('h08, 0, 6, 16'd1);
        imem[31] = enc_i('h2B, 0, 6, 16'd84);
        imem[32] = enc_i('h04, 0, 0, 16'hFFFF);
        start_prog(1'b0);
        repeat (60) @(negedge clk);
        chk("R7 R8 jal target then jr return stores r4", dmem[16], 32'd42);
        chk("R7 link register value", dmem[17], BASE + 32'd36);
        chk("R6 beq/bne path selection", dmem[18], 32'd11);
        chk("R9 register 0 stays zero", dmem[19], 32'd0);
        chk("R10 unknown encodings leave r3", dmem[20], 32'd11);
        chk("R5 store with negative offset", dmem[2], 32'd7);
        chk("R5 load then store back", dmem[23], 32'd7);
        chk("R6 backward branch reached", dmem[21], 32'd1);
        chk("R10 no extra memory writes", 32'(st_cnt), 32'd8);
        chk("R6 self branch holds address", imem_addr, BASE + 32'd128);
    endtask

    initial begin
        for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
                run_sweep(ia, ib, (ia == 0 && ib == 0));
        run_control();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule